// File: doc/BRIEF.md
# Stack-Addressed Floating-Point Register File Controller

This block owns an eight-entry file of 80-bit extended-precision registers. Software and the arithmetic pipeline see the file as a circular stack. A 3-bit top pointer sits inside the status word, and every stack-relative index i selects physical register (top + i) mod 8. The block keeps three words. The control word holds the exception masks, precision control, rounding mode and infinity control. The status word holds the exception flags, the stack-fault and error-summary bits, the four condition codes, the top pointer and a busy bit. The tag word holds a 2-bit tag per register.

Commands arrive one per cycle on a valid/opcode/index/data interface. Push, pop and stack-relative read/write keep each tag up to date. Each written value is classified from its exponent and significand. A push onto an occupied slot is flagged as an overflow fault, and a pop or read of an empty slot is flagged as an underflow fault. Free, increment-top and decrement-top change the stack shape without touching data. A packed-integer alias mode reaches a physical register directly through its low 64 bits and marks every register valid. Comparison results from an external unit are folded into the condition codes. Arithmetic units can raise exception flags, and those flags feed the error-summary bit through the control-word masks. Read data returns on a registered response one cycle after the command.

Top module: `fstk_ctrl`

## Requirements
- R1: While reset is high and on the cycle after reset, the control word is 0x037F, the status word is 0x0000, the tag word is 0xFFFF (every register empty) and rsp_valid is 0.
- R2: Read (op 3), write (op 4) and free (op 5) address physical register (top + cmd_idx) mod 8. Free sets that register's tag to 11 (empty).
- R3: Push (op 1) decrements top modulo 8, stores cmd_data at the new top and sets its tag. Pop (op 2) returns the register at top, sets its tag to empty and increments top. Read and pop give rsp_valid with rsp_data on the cycle after the command.
- R4: A written value is classified by its exponent (bits 78:64) and significand (bits 63:0). Exponent and significand both zero give tag 01 (zero). Exponent zero with a non-zero significand, or an all-ones exponent, gives tag 10 (special). Any other value gives tag 00 (valid). Register k's tag is tag-word bits 2k+1:2k.
- R5: A push whose target tag is not empty writes nothing and leaves top and the tags unchanged. It sets C1 (status bit 9) and stack-fault (bit 6).
- R6: A pop or read of an empty register clears C1 and sets stack-fault. Top and the tags stay unchanged, and the response carries rsp_fault = 1.
- R7: Increment-top (op 6) and decrement-top (op 7) move top by one modulo 8 and leave every tag unchanged.
- R8: Packed read (op 8) returns the low 64 bits of physical register cmd_idx, zero-extended. Packed write (op 9) stores cmd_data[63:0] with the upper 16 bits all ones. Both clear the whole tag word to 0.
- R9: Compare (op 13) takes code cmd_data[1:0] and sets {C3, C2, C0} (status bits 14, 10, 8). Code 00 (greater) gives 000, 01 (less) gives 001, 10 (equal) gives 100 and 11 (unordered) gives 111. C1 is left unchanged.
- R10: Clear-exceptions (op 10) clears status bits 7:0 and the busy bit 15. The condition codes and top are kept.
- R11: Load-control (op 11) loads the control word from cmd_data[15:0]. Raise (op 12) ORs cmd_data[5:0] into status bits 5:0. The error-summary bit 7 becomes set whenever stack-fault is set or a flag in bits 5:0 is set while its mask bit in control bits 5:0 is 0.
- R12: Status-word layout: flags in bits 0–5, stack-fault in bit 6, summary in bit 7, C0 in bit 8, C1 in bit 9, C2 in bit 10, top in bits 13:11, C3 in bit 14, busy in bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_idx | input | 3 | Stack-relative index, or physical index for packed operations |
| cmd_data | input | 80 | Write value, control word, flags or compare code |
| rsp_valid | output | 1 | Registered response for pop, read and packed read |
| rsp_data | output | 80 | Response data |
| rsp_fault | output | 1 | Response was an underflow |
| ctrl_word | output | 16 | Control word |
| stat_word | output | 16 | Status word |
| tag_word | output | 16 | Packed tag word |

## Verification
The bench builds the block with its default parameters: eight registers, 80-bit values with a 15-bit exponent, and a 64-bit packed alias. With these values, eight pushes bring top through its wrap from 0 to 7 and back to 0 and fill every slot, so a ninth push reaches the full-stack overflow. The 80-bit layout puts the classification edges within reach: zero, denormal, infinity and normal operands each select a different tag. Relative indices that cross the wrap confirm the modulo-8 address mapping.

// File: rtl/fstk_pkg.sv
package fstk_pkg;

  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_PUSH   = 4'd1,
    OP_POP    = 4'd2,
    OP_READ   = 4'd3,
    OP_WRITE  = 4'd4,
    OP_FREE   = 4'd5,
    OP_INCTOP = 4'd6,
    OP_DECTOP = 4'd7,
    OP_PKRD   = 4'd8,
    OP_PKWR   = 4'd9,
    OP_CLREX  = 4'd10,
    OP_LDCW   = 4'd11,
    OP_RAISE  = 4'd12,
    OP_CMP    = 4'd13
  } fstk_op_e;

  localparam logic [1:0] TAG_VALID   = 2'b00;
  localparam logic [1:0] TAG_ZERO    = 2'b01;
  localparam logic [1:0] TAG_SPECIAL = 2'b10;
  localparam logic [1:0] TAG_EMPTY   = 2'b11;

  localparam logic [15:0] CW_RESET = 16'h037F;

  // status word bit positions
  localparam int SW_SF   = 6;
  localparam int SW_ES   = 7;
  localparam int SW_C0   = 8;
  localparam int SW_C1   = 9;
  localparam int SW_C2   = 10;
  localparam int SW_TOP  = 11;
  localparam int SW_C3   = 14;
  localparam int SW_BUSY = 15;

endpackage

// File: rtl/fstk_classify.sv
module fstk_classify #(
  parameter int DW   = 80,
  parameter int EXPW = 15
) (
  input  logic [DW-1:0] value,
  output logic [1:0]    tag
);
  localparam int SIGW = DW - 1 - EXPW;

  logic [EXPW-1:0] expo;
  logic [SIGW-1:0] sig;

  assign expo = value[DW-2 -: EXPW];
  assign sig  = value[SIGW-1:0];

  always_comb begin
    if (expo == '0) begin
      tag = (sig == '0) ? fstk_pkg::TAG_ZERO : fstk_pkg::TAG_SPECIAL;
    end else if (&expo) begin
      tag = fstk_pkg::TAG_SPECIAL;
    end else begin
      tag = fstk_pkg::TAG_VALID;
    end
  end
endmodule

// File: rtl/fstk_array.sv
module fstk_array #(
  parameter int NREG = 8,
  parameter int DW   = 80,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fstk_tags.sv
module fstk_tags #(
  parameter int NREG  = 8,
  localparam int AW   = $clog2(NREG),
  localparam int TAGW = 2 * NREG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic [AW-1:0]   set_idx,
  input  logic [1:0]      set_val,
  input  logic            clr_all,
  output logic [TAGW-1:0] tag_word
);
  for (genvar g = 0; g < NREG; g++) begin : g_tag
    logic [1:0] tag_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q <= fstk_pkg::TAG_EMPTY;
      end else if (clr_all) begin
        tag_q <= fstk_pkg::TAG_VALID;
      end else if (set_en && (set_idx == AW'(g))) begin
        tag_q <= set_val;
      end
    end
    assign tag_word[2*g +: 2] = tag_q;
  end
endmodule

// File: rtl/fstk_status.sv
module fstk_status #(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_cw,
  input  logic [15:0]   cw_in,
  input  logic          clr_ex,
  input  logic          raise_en,
  input  logic [5:0]    raise_flags,
  input  logic          fault_en,
  input  logic          fault_c1,
  input  logic          cmp_en,
  input  logic [1:0]    cmp_code,
  input  logic          top_en,
  input  logic [AW-1:0] top_in,
  output logic [15:0]   ctrl_word,
  output logic [15:0]   stat_word
);
  import fstk_pkg::*;

  logic [15:0] cw_q, sw_q, sw_nxt;

  always_comb begin
    sw_nxt = sw_q;
    if (clr_ex) begin
      sw_nxt[7:0]     = '0;
      sw_nxt[SW_BUSY] = 1'b0;
    end
    if (raise_en) sw_nxt[5:0] = sw_q[5:0] | raise_flags;
    if (fault_en) begin
      sw_nxt[SW_SF] = 1'b1;
      sw_nxt[SW_C1] = fault_c1;
    end
    if (cmp_en) begin
      case (cmp_code)
        2'b00:   {sw_nxt[SW_C3], sw_nxt[SW_C2], sw_nxt[SW_C0]} = 3'b000;
        2'b01:   {sw_nxt[SW_C3], sw_nxt[SW_C2], sw_nxt[SW_C0]} = 3'b001;
        2'b10:   {sw_nxt[SW_C3], sw_nxt[SW_C2], sw_nxt[SW_C0]} = 3'b100;
        default: {sw_nxt[SW_C3], sw_nxt[SW_C2], sw_nxt[SW_C0]} = 3'b111;
      endcase
    end
    if (top_en) sw_nxt[SW_TOP +: 3] = 3'(top_in);
    if (sw_nxt[SW_SF] || ((sw_nxt[5:0] & ~cw_q[5:0]) != 6'd0)) sw_nxt[SW_ES] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cw_q <= CW_RESET;
      sw_q <= '0;
    end else begin
      if (ld_cw) cw_q <= cw_in;
      sw_q <= sw_nxt;
    end
  end

  assign ctrl_word = cw_q;
  assign stat_word = sw_q;
endmodule

// File: rtl/fstk_ctrl.sv
module fstk_ctrl #(
  parameter int NREG  = 8,
  parameter int DW    = 80,
  parameter int EXPW  = 15,
  parameter int PKW   = 64,
  localparam int AW   = $clog2(NREG),
  localparam int TAGW = 2 * NREG
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [AW-1:0]   cmd_idx,
  input  logic [DW-1:0]   cmd_data,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data,
  output logic            rsp_fault,
  output logic [15:0]     ctrl_word,
  output logic [15:0]     stat_word,
  output logic [TAGW-1:0] tag_word
);
  import fstk_pkg::*;

  fstk_op_e      op;
  logic [AW-1:0] top, top_dec, top_inc, rel_idx;
  logic [1:0]    cls_tag;

  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic          tg_set, tg_clr;
  logic [AW-1:0] tg_idx;
  logic [1:0]    tg_val;

  logic          top_en, flt_en, flt_c1, under, ld_cw, clr_ex, raise_en, cmp_en;
  logic          rsp_op, pk_rd;
  logic [AW-1:0] top_nxt;

  logic          rsp_valid_q, rsp_fault_q, pk_q;

  assign op      = fstk_op_e'(cmd_op);
  assign top     = stat_word[SW_TOP +: AW];
  assign top_dec = top - 1'b1;
  assign top_inc = top + 1'b1;
  assign rel_idx = top + cmd_idx;

  function automatic logic slot_empty(input logic [TAGW-1:0] tw, input logic [AW-1:0] k);
    return tw[2*k +: 2] == TAG_EMPTY;
  endfunction

  fstk_classify #(.DW(DW), .EXPW(EXPW)) u_cls (
    .value (cmd_data),
    .tag   (cls_tag)
  );

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = rel_idx;
    mem_wdata = cmd_data;
    mem_re    = 1'b0;
    mem_raddr = rel_idx;
    tg_set    = 1'b0;
    tg_idx    = rel_idx;
    tg_val    = cls_tag;
    tg_clr    = 1'b0;
    top_en    = 1'b0;
    top_nxt   = top;
    flt_en    = 1'b0;
    flt_c1    = 1'b0;
    under     = 1'b0;
    ld_cw     = 1'b0;
    clr_ex    = 1'b0;
    raise_en  = 1'b0;
    cmp_en    = 1'b0;
    rsp_op    = 1'b0;
    pk_rd     = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_PUSH: begin
          if (!slot_empty(tag_word, top_dec)) begin
            flt_en = 1'b1;
            flt_c1 = 1'b1;
          end else begin
            mem_we    = 1'b1;
            mem_waddr = top_dec;
            tg_set    = 1'b1;
            tg_idx    = top_dec;
            top_en    = 1'b1;
            top_nxt   = top_dec;
          end
        end
        OP_POP: begin
          rsp_op    = 1'b1;
          mem_raddr = top;
          if (slot_empty(tag_word, top)) begin
            flt_en = 1'b1;
            under  = 1'b1;
          end else begin
            mem_re  = 1'b1;
            tg_set  = 1'b1;
            tg_idx  = top;
            tg_val  = TAG_EMPTY;
            top_en  = 1'b1;
            top_nxt = top_inc;
          end
        end
        OP_READ: begin
          rsp_op = 1'b1;
          if (slot_empty(tag_word, rel_idx)) begin
            flt_en = 1'b1;
            under  = 1'b1;
          end else begin
            mem_re = 1'b1;
          end
        end
        OP_WRITE: begin
          mem_we = 1'b1;
          tg_set = 1'b1;
        end
        OP_FREE: begin
          tg_set = 1'b1;
          tg_val = TAG_EMPTY;
        end
        OP_INCTOP: begin
          top_en  = 1'b1;
          top_nxt = top_inc;
        end
        OP_DECTOP: begin
          top_en  = 1'b1;
          top_nxt = top_dec;
        end
        OP_PKRD: begin
          rsp_op    = 1'b1;
          pk_rd     = 1'b1;
          mem_re    = 1'b1;
          mem_raddr = cmd_idx;
          tg_clr    = 1'b1;
        end
        OP_PKWR: begin
          mem_we    = 1'b1;
          mem_waddr = cmd_idx;
          mem_wdata = {{(DW-PKW){1'b1}}, cmd_data[PKW-1:0]};
          tg_clr    = 1'b1;
        end
        OP_CLREX: clr_ex   = 1'b1;
        OP_LDCW:  ld_cw    = 1'b1;
        OP_RAISE: raise_en = 1'b1;
        OP_CMP:   cmp_en   = 1'b1;
        default: ;
      endcase
    end
  end

  fstk_array #(.NREG(NREG), .DW(DW)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  fstk_tags #(.NREG(NREG)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .set_en   (tg_set),
    .set_idx  (tg_idx),
    .set_val  (tg_val),
    .clr_all  (tg_clr),
    .tag_word (tag_word)
  );

  fstk_status #(.NREG(NREG)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .ld_cw       (ld_cw),
    .cw_in       (cmd_data[15:0]),
    .clr_ex      (clr_ex),
    .raise_en    (raise_en),
    .raise_flags (cmd_data[5:0]),
    .fault_en    (flt_en),
    .fault_c1    (flt_c1),
    .cmp_en      (cmp_en),
    .cmp_code    (cmd_data[1:0]),
    .top_en      (top_en),
    .top_in      (top_nxt),
    .ctrl_word   (ctrl_word),
    .stat_word   (stat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      pk_q        <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_op;
      rsp_fault_q <= under;
      pk_q        <= pk_rd;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_data  = pk_q ? DW'(mem_rdata[PKW-1:0]) : mem_rdata;
endmodule

// File: rtl/fstk_ctrl_chk.sv
module fstk_ctrl_chk #(
  parameter int NREG  = 8,
  localparam int AW   = $clog2(NREG),
  localparam int TAGW = 2 * NREG
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_valid,
  input logic [3:0]      cmd_op,
  input logic [1:0]      cmd_code,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [15:0]     ctrl_word,
  input logic [15:0]     stat_word,
  input logic [TAGW-1:0] tag_word
);
  import fstk_pkg::*;

  logic [AW-1:0] top_c, dec_c, top_d;
  assign top_c = stat_word[SW_TOP +: AW];
  assign dec_c = top_c - 1'b1;

  always_ff @(posedge clk) top_d <= top_c;

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (ctrl_word == CW_RESET && stat_word == 16'h0000 &&
             tag_word == {TAGW{1'b1}} && !rsp_valid));

  // R3
  a_r3_pop_moves_top: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_POP && tag_word[2*top_c +: 2] != TAG_EMPTY)
    |=> (top_c == AW'(top_d + 1'b1) && tag_word[2*top_d +: 2] == TAG_EMPTY && rsp_valid && !rsp_fault));

  // R5
  a_r5_no_overflow_write: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PUSH && tag_word[2*dec_c +: 2] != TAG_EMPTY)
    |=> (stat_word[SW_C1] && stat_word[SW_SF] && $stable(top_c) && $stable(tag_word)));

  // R6
  a_r6_underflow_pop: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_POP && tag_word[2*top_c +: 2] == TAG_EMPTY)
    |=> (!stat_word[SW_C1] && stat_word[SW_SF] && rsp_fault && $stable(top_c)));

  // R8
  a_r8_packed_clears_tags: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_PKRD || cmd_op == OP_PKWR)) |=> (tag_word == '0));

  // R9
  a_r9_unordered: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_CMP && cmd_code == 2'b11)
    |=> (stat_word[SW_C0] && stat_word[SW_C2] && stat_word[SW_C3]));

  // R10
  a_r10_clear_flags: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_CLREX) |=> (stat_word[7:0] == 8'h00 && !stat_word[SW_BUSY]));

  // R11
  a_r11_fault_summary: assert property (@(posedge clk) disable iff (rst)
    stat_word[SW_SF] |-> stat_word[SW_ES]);
endmodule

bind fstk_ctrl fstk_ctrl_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_code  (cmd_data[1:0]),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .ctrl_word (ctrl_word),
  .stat_word (stat_word),
  .tag_word  (tag_word)
);

// File: tb/sim_fstk_ctrl.sv
module sim_fstk_ctrl;
  localparam logic [79:0] V_ONE  = 80'h3FFF_8000000000000000;
  localparam logic [79:0] V_ZERO = 80'h0;
  localparam logic [79:0] V_INF  = 80'h7FFF_8000000000000000;
  localparam logic [79:0] V_DEN  = 80'h0000_0000000000000001;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [2:0]  idx;
    logic [79:0] data;
    logic        rsp;
    logic        fault;
    logic [79:0] rd;
    logic [15:0] sw;
    logic [15:0] tw;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{4'd3,  4'd1,  3'd0, V_ONE,  1'b0, 1'b0, 80'h0,  16'h3800, 16'h3FFF}, // R3 push to phys 7
    '{4'd4,  4'd1,  3'd0, V_ZERO, 1'b0, 1'b0, 80'h0,  16'h3000, 16'h1FFF}, // R4 zero tag
    '{4'd4,  4'd1,  3'd0, V_INF,  1'b0, 1'b0, 80'h0,  16'h2800, 16'h1BFF}, // R4 special tag
    '{4'd2,  4'd3,  3'd2, 80'h0,  1'b1, 1'b0, V_ONE,  16'h2800, 16'h1BFF}, // R2 read rel 2 -> phys 7
    '{4'd2,  4'd4,  3'd1, V_DEN,  1'b0, 1'b0, 80'h0,  16'h2800, 16'h2BFF}, // R2 write rel 1, denormal
    '{4'd3,  4'd2,  3'd0, 80'h0,  1'b1, 1'b0, V_INF,  16'h3000, 16'h2FFF}, // R3 pop
    '{4'd3,  4'd2,  3'd0, 80'h0,  1'b1, 1'b0, V_DEN,  16'h3800, 16'h3FFF}, // R3 pop
    '{4'd3,  4'd2,  3'd0, 80'h0,  1'b1, 1'b0, V_ONE,  16'h0000, 16'hFFFF}, // R3 pop wraps top to 0
    '{4'd6,  4'd2,  3'd0, 80'h0,  1'b1, 1'b1, 80'h0,  16'h00C0, 16'hFFFF}, // R6 pop empty
    '{4'd10, 4'd10, 3'd0, 80'h0,  1'b0, 1'b0, 80'h0,  16'h0000, 16'hFFFF}, // R10 clear
    '{4'd9,  4'd13, 3'd0, 80'h3,  1'b0, 1'b0, 80'h0,  16'h4500, 16'hFFFF}, // R9 unordered
    '{4'd9,  4'd13, 3'd0, 80'h1,  1'b0, 1'b0, 80'h0,  16'h0100, 16'hFFFF}, // R9 less
    '{4'd7,  4'd7,  3'd0, 80'h0,  1'b0, 1'b0, 80'h0,  16'h3900, 16'hFFFF}, // R7 dec wraps to 7
    '{4'd7,  4'd6,  3'd0, 80'h0,  1'b0, 1'b0, 80'h0,  16'h0100, 16'hFFFF}  // R7 inc wraps to 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [2:0]  cmd_idx = 3'd0;
  logic [79:0] cmd_data = 80'h0;
  logic        rsp_valid, rsp_fault;
  logic [79:0] rsp_data;
  logic [15:0] ctrl_word, stat_word, tag_word;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fstk_ctrl u0 (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .cmd_data  (cmd_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_fault (rsp_fault),
    .ctrl_word (ctrl_word),
    .stat_word (stat_word),
    .tag_word  (tag_word)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] o, input logic [2:0] i, input logic [79:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = o;
    cmd_idx   = i;
    cmd_data  = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: values held in reset
    chk("R1 ctrl in reset", 80'(ctrl_word), 80'h037F);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ctrl", 80'(ctrl_word), 80'h037F);
    chk("R1 status", 80'(stat_word), 80'h0);
    chk("R1 tags", 80'(tag_word), 80'hFFFF);
    chk("R1 rsp_valid", 80'(rsp_valid), 80'h0);

    for (int k = 0; k < NVEC; k++) begin
      do_op(VEC[k].op, VEC[k].idx, VEC[k].data);
      chk($sformatf("R%0d step %0d rsp_valid", VEC[k].req, k), 80'(rsp_valid), 80'(VEC[k].rsp));
      if (VEC[k].rsp) begin
        chk($sformatf("R%0d step %0d fault", VEC[k].req, k), 80'(rsp_fault), 80'(VEC[k].fault));
        if (!VEC[k].fault)
          chk($sformatf("R%0d step %0d data", VEC[k].req, k), rsp_data, VEC[k].rd);
      end
      chk($sformatf("R%0d step %0d status", VEC[k].req, k), 80'(stat_word), 80'(VEC[k].sw));
      chk($sformatf("R%0d step %0d tags", VEC[k].req, k), 80'(tag_word), 80'(VEC[k].tw));
    end

    // R9: greater clears C3/C2/C0
    do_op(4'd13, 3'd0, 80'h0);
    chk("R9 greater", 80'(stat_word), 80'h0000);

    // R3 / R7: eight pushes wrap top back to 0 and fill the file
    for (int k = 0; k < 8; k++) do_op(4'd1, 3'd0, V_ONE | 80'(k));
    chk("R3 full stack top", 80'(stat_word), 80'h0000);
    chk("R3 full stack tags", 80'(tag_word), 80'h0000);

    // R5: overflow push changes nothing, C1=1, fault + summary
    do_op(4'd1, 3'd0, V_ZERO);
    chk("R5 overflow status", 80'(stat_word), 80'h02C0);
    chk("R5 overflow tags", 80'(tag_word), 80'h0000);
    do_op(4'd3, 3'd0, 80'h0);
    chk("R5 top value kept", rsp_data, V_ONE | 80'd7);

    // R2: free rel 0 -> phys 0
    do_op(4'd5, 3'd0, 80'h0);
    chk("R2 free", 80'(tag_word), 80'h0003);

    // R8: packed read of phys 3 (5th push) zero-extends, clears tags
    do_op(4'd8, 3'd3, 80'h0);
    chk("R8 packed read", rsp_data, 80'h0000_8000000000000004);
    chk("R8 packed read tags", 80'(tag_word), 80'h0000);
    do_op(4'd5, 3'd1, 80'h0);
    chk("R2 free rel 1", 80'(tag_word), 80'h000C);
    do_op(4'd9, 3'd5, 80'hABCD_1122334455667788);
    chk("R8 packed write tags", 80'(tag_word), 80'h0000);
    do_op(4'd3, 3'd5, 80'h0);
    chk("R8 packed write value", rsp_data, 80'hFFFF_1122334455667788);

    // R6: read of empty register
    do_op(4'd5, 3'd2, 80'h0);
    do_op(4'd3, 3'd2, 80'h0);
    chk("R6 read fault", 80'(rsp_fault), 80'h1);
    chk("R6 read status", 80'(stat_word), 80'h00C0);
    chk("R6 tags unchanged", 80'(tag_word), 80'h0030);

    // R10 / R11
    do_op(4'd10, 3'd0, 80'h0);
    chk("R10 clear", 80'(stat_word), 80'h0000);
    do_op(4'd11, 3'd0, 80'h037E);
    chk("R11 load control", 80'(ctrl_word), 80'h037E);
    do_op(4'd12, 3'd0, 80'h20);
    chk("R11 masked raise", 80'(stat_word), 80'h0020);
    do_op(4'd12, 3'd0, 80'h01);
    chk("R11 unmasked raise", 80'(stat_word), 80'h00A1);
    do_op(4'd10, 3'd0, 80'h0);
    chk("R12 clear keeps top/codes", 80'(stat_word), 80'h0000);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule